// File: doc/BRIEF.md
# Display AC-Bias Generator with Transition Interrupt

This block drives the polarity-reversal (AC bias) pin of a display controller and raises a sticky status bit after a programmed number of bias reversals. A line-clock divider counts single-cycle line pulses. Each time it expires it flips an internal toggle. In passive mode that toggle is the pin itself. In active mode the pin instead marks valid pixel data as an output enable, while the toggle keeps running out of sight.

A second, narrow down counter counts toggle flips. When it runs out, the status bit is set and the interrupt request follows it. Counting then halts until the CPU clears the status bit with a one-cycle pulse. A transitions field of zero turns the interrupt function off.

Top module: `acbias_irq`

## Requirements
- R1: After reset, `bias_out`, `stat_flag` and `irq` are all 0.
- R2: In passive mode (`active_mode`=0) while enabled, `bias_out` starts at 0 and inverts on every (N+1)-th line pulse, where N is `line_div_cfg` (0..255 gives 1..256 pulses). It is stable between those pulses.
- R3: With `xitions_cfg`=K (1..15), `stat_flag` is set on the clock edge of the K-th toggle flip counted since enable or since the last clear.
- R4: `stat_flag` is sticky and stays set until `stat_clr` is pulsed. `irq` equals `stat_flag` at all times.
- R5: While `stat_flag` is set, toggle flips are not counted. After a clear, K further flips are needed to set it again.
- R6: With `xitions_cfg`=0, `stat_flag` never sets, however many line pulses arrive.
- R7: In active mode (`active_mode`=1) while enabled, `bias_out` equals `pix_valid` in the same cycle, whatever the value of `line_div_cfg`.
- R8: In active mode, the hidden toggle still flips every N+1 line pulses, and those flips set `stat_flag` exactly as in R3.
- R9: While `ctl_en` is 0, `bias_out` is 0 and both counters reload from their fields. After re-enable, counting restarts from the field values with the toggle at 0. `stat_flag` keeps its value.
- R10: If `stat_clr` arrives in the same cycle as a toggle flip, the clear wins and that flip is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable |
| line_pulse | input | 1 | One-cycle line-clock pulse |
| active_mode | input | 1 | 0 = passive (pin is bias), 1 = active (pin is output enable) |
| line_div_cfg | input | 8 | Line pulses per toggle minus one |
| xitions_cfg | input | 4 | Toggle flips per interrupt, 0 = off |
| pix_valid | input | 1 | Pixel data currently driven |
| stat_clr | input | 1 | One-cycle CPU clear of the status bit |
| bias_out | output | 1 | AC bias pin or output enable |
| stat_flag | output | 1 | Sticky count-reached status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a CPU clear that lands in exactly the cycle of a toggle flip while the status bit is still low with a partial count held. Only that case shows whether the flip leaked into the reloaded counter. The bench reaches it with the divider set to expire on every pulse and K=2. It counts one flip, then issues the clear together with the next line pulse, and checks that two further flips are needed. In active mode, the hidden toggle is reached only through the status bit, so the expected flip count is derived from pulse arithmetic alone.

// File: rtl/acbias_pkg.sv
package acbias_pkg;
    localparam int LINE_W = 8;
    localparam int XIT_W  = 4;

    typedef enum logic {
        MODE_PASSIVE = 1'b0,
        MODE_ACTIVE  = 1'b1
    } pin_mode_e;

    typedef struct packed {
        logic [LINE_W-1:0] remain;
        logic              tgl;
    } div_state_t;

    typedef struct packed {
        logic [XIT_W-1:0] remain;
        logic             done;
    } evt_state_t;

    function automatic logic cnt_last(input logic [XIT_W-1:0] v);
        return (v <= XIT_W'(1));
    endfunction
endpackage

// File: rtl/acbias_line_div.sv
module acbias_line_div
    import acbias_pkg::*;
#(
    parameter int W = LINE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         line_pulse,
    input  logic [W-1:0] reload_val,
    output logic         expire,
    output logic         tgl
);
    logic [W-1:0] remain_q;
    logic         tgl_q;

    assign expire = en && line_pulse && (remain_q == '0);
    assign tgl    = tgl_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            remain_q <= reload_val;
            tgl_q    <= 1'b0;
        end else if (line_pulse) begin
            if (remain_q == '0) begin
                remain_q <= reload_val;
                tgl_q    <= ~tgl_q;
            end else begin
                remain_q <= remain_q - W'(1);
            end
        end
    end
endmodule

// File: rtl/acbias_evt_cnt.sv
module acbias_evt_cnt
    import acbias_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             flip,
    input  logic [XIT_W-1:0] cfg,
    input  logic             clr,
    output logic             stat
);
    evt_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.done   = 1'b0;
            st_d.remain = cfg;
        end else if (st_q.done || !en || cfg == '0) begin
            st_d.remain = cfg;
        end else if (flip) begin
            if (cnt_last(st_q.remain)) begin
                st_d.done   = 1'b1;
                st_d.remain = cfg;
            end else begin
                st_d.remain = st_q.remain - XIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.remain <= cfg;
            st_q.done   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.done;
endmodule

// File: rtl/acbias_pin_mux.sv
module acbias_pin_mux
    import acbias_pkg::*;
(
    input  logic      en,
    input  pin_mode_e mode,
    input  logic      tgl,
    input  logic      pix_valid,
    output logic      pin
);
    always_comb begin
        unique case (mode)
            MODE_ACTIVE:  pin = en && pix_valid;
            default:      pin = en && tgl;
        endcase
    end
endmodule

// File: rtl/acbias_irq.sv
module acbias_irq
    import acbias_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_en,
    input  logic              line_pulse,
    input  logic              active_mode,
    input  logic [LINE_W-1:0] line_div_cfg,
    input  logic [XIT_W-1:0]  xitions_cfg,
    input  logic              pix_valid,
    input  logic              stat_clr,
    output logic              bias_out,
    output logic              stat_flag,
    output logic              irq
);
    logic      flip;
    logic      int_tgl;
    pin_mode_e mode;

    assign mode = pin_mode_e'(active_mode);

    acbias_line_div #(.W(LINE_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .en         (ctl_en),
        .line_pulse (line_pulse),
        .reload_val (line_div_cfg),
        .expire     (flip),
        .tgl        (int_tgl)
    );

    acbias_evt_cnt u_evt (
        .clk  (clk),
        .rst  (rst),
        .en   (ctl_en),
        .flip (flip),
        .cfg  (xitions_cfg),
        .clr  (stat_clr),
        .stat (stat_flag)
    );

    acbias_pin_mux u_mux (
        .en        (ctl_en),
        .mode      (mode),
        .tgl       (int_tgl),
        .pix_valid (pix_valid),
        .pin       (bias_out)
    );

    assign irq = stat_flag;
endmodule

// File: rtl/acbias_irq_chk.sv
module acbias_irq_chk
    import acbias_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ctl_en,
    input logic             line_pulse,
    input logic             active_mode,
    input logic [XIT_W-1:0] xitions_cfg,
    input logic             stat_clr,
    input logic             bias_out,
    input logic             stat_flag
);
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_flag && !stat_clr) |=> stat_flag); // R4

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        stat_clr |=> !stat_flag); // R10

    AST_ZERO_CFG_OFF: assert property (@(posedge clk) disable iff (rst)
        (xitions_cfg == '0 && !stat_flag) |=> !stat_flag); // R6

    AST_SET_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_flag) |-> ($past(line_pulse) && $past(ctl_en))); // R3

    AST_PASSIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && !active_mode && !line_pulse) |=>
            (active_mode || !ctl_en || $stable(bias_out))); // R2

    AST_DIS_LOW: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |-> !bias_out); // R9
endmodule

bind acbias_irq acbias_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_en      (ctl_en),
    .line_pulse  (line_pulse),
    .active_mode (active_mode),
    .xitions_cfg (xitions_cfg),
    .stat_clr    (stat_clr),
    .bias_out    (bias_out),
    .stat_flag   (stat_flag)
);

// File: tb/acbias_irq_tb.sv
module acbias_irq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_en = 1'b0;
    logic       line_pulse = 1'b0;
    logic       active_mode = 1'b0;
    logic [7:0] line_div_cfg = 8'd0;
    logic [3:0] xitions_cfg = 4'd0;
    logic       pix_valid = 1'b0;
    logic       stat_clr = 1'b0;
    logic       bias_out, stat_flag, irq;

    int n_vec = 0;
    int n_bad = 0;

    // behavioural model state
    int  m_p = 0;
    int  m_c = 0;
    bit  m_tg = 0;
    bit  m_stat = 0;

    always #2 clk = ~clk;

    acbias_irq u_dut (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .line_pulse(line_pulse),
        .active_mode(active_mode), .line_div_cfg(line_div_cfg),
        .xitions_cfg(xitions_cfg), .pix_valid(pix_valid), .stat_clr(stat_clr),
        .bias_out(bias_out), .stat_flag(stat_flag), .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // one clock with given stimulus, model update, then checks
    task automatic tick(input bit en, input bit lp, input bit clr, input bit pv,
                        input string req);
        bit flip;
        @(negedge clk);
        ctl_en = en; line_pulse = lp; stat_clr = clr; pix_valid = pv;
        @(posedge clk);
        #1;
        flip = 0;
        if (!en) begin
            m_p = 0; m_tg = 0;
        end else if (lp) begin
            if (m_p == int'(line_div_cfg)) begin
                m_p = 0; m_tg = ~m_tg; flip = 1;
            end else m_p++;
        end
        if (clr) begin
            m_stat = 0; m_c = 0;
        end else if (!en || m_stat || xitions_cfg == 0) begin
            m_c = 0;
        end else if (flip) begin
            m_c++;
            if (m_c == int'(xitions_cfg)) begin m_stat = 1; m_c = 0; end
        end
        chk(req, bias_out, en ? (active_mode ? pv : m_tg) : 1'b0);
        chk(req, stat_flag, m_stat);
        chk("R4", irq, m_stat);
        line_pulse = 0; stat_clr = 0;
    endtask

    task automatic setup(input bit act, input int n, input int k);
        active_mode = act;
        line_div_cfg = 8'(n);
        xitions_cfg = 4'(k);
        tick(0, 0, 1, 0, "R9");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int nlist[5] = '{0, 1, 2, 4, 7};
        logic [7:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", bias_out, 1'b0);
        chk("R1", stat_flag, 1'b0);
        chk("R1", irq, 1'b0);
        rst = 1'b0;

        // R2 R3 R5: passive sweep
        foreach (nlist[i]) begin
            for (int k = 1; k < 16; k++) begin
                setup(0, nlist[i], k);
                for (int p = 0; p < (k + 1) * (nlist[i] + 1) + 1; p++) begin
                    tick(1, 1, 0, 0, "R3");
                    tick(1, 0, 0, 0, "R2");
                end
                tick(1, 0, 1, 0, "R5");
                for (int p = 0; p < k * (nlist[i] + 1); p++)
                    tick(1, 1, 0, 0, "R5");
            end
        end

        // R2 widest divide
        setup(0, 255, 1);
        for (int p = 0; p < 2 * 256 + 2; p++) tick(1, 1, 0, 0, "R2");

        // R6: interrupt off
        setup(0, 0, 0);
        for (int p = 0; p < 60; p++) tick(1, 1, 0, 0, "R6");

        // R7 R8: active mode, pin follows pix_valid
        lfsr = 8'h5a;
        for (int s = 0; s < 2; s++) begin
            setup(1, s == 0 ? 2 : 255, 3);
            for (int p = 0; p < (s == 0 ? 40 : 800); p++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                tick(1, lfsr[0], 0, lfsr[1], "R7");
                tick(1, 1, 0, lfsr[2], "R8");
            end
        end

        // R10: clear coincident with a flip, partial count held
        setup(0, 0, 2);
        tick(1, 1, 0, 0, "R10");
        tick(1, 1, 1, 0, "R10");
        chk("R10", stat_flag, 1'b0);
        tick(1, 1, 0, 0, "R10");
        tick(1, 1, 0, 0, "R10");
        chk("R10", stat_flag, 1'b1);
        // clear coincident while set
        tick(1, 1, 1, 0, "R10");
        tick(1, 1, 0, 0, "R10");
        chk("R10", stat_flag, 1'b0);

        // R9: disable mid-count, status retained, restart from field
        setup(0, 3, 1);
        tick(1, 1, 0, 0, "R9");
        tick(1, 1, 0, 0, "R9");
        tick(0, 1, 0, 1, "R9");
        for (int p = 0; p < 4; p++) tick(1, 1, 0, 0, "R9");
        chk("R9", bias_out, 1'b1);
        tick(0, 0, 0, 0, "R9");
        chk("R9", stat_flag, 1'b1);
        active_mode = 1;
        tick(0, 0, 0, 1, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule